// File: doc/BRIEF.md
# Way-Halting Four-Way Cache Lookup

This block is the lookup and refill core of a four-way set-associative cache. The main tag and data arrays are only read for the ways that could possibly hold the requested line. A small side store keeps the lowest few bits of every way's tag for every set. When a request arrives, those short tags are compared with the matching bits of the request address. The comparison runs in the same cycle as, and in parallel with, the selection of the set from the index field. The result is one enable per way. A way whose short tag differs, or whose line is invalid, has its full tag read and its data read blocked for that access.

A request carries an address and a valid strobe, and its answer (hit, way number, line data) appears one clock later. This is the same latency as a cache without the filter. On a miss, the environment supplies the line through a refill port. The refill writes the victim way's full tag, short tag, valid bit and data together on one clock edge. The per-way enables are brought out so that the caller can see which arrays were read.

Top module: `way_halt_cache`

## Requirements
- R1: After reset every line is invalid: `rsp_valid` is 0, `way_en` is 0, and the first request of any address misses.
- R2: During a request cycle, `way_en[w]` is 1 exactly when way w of the indexed set is valid and its stored tag bits [3:0] equal request tag bits [3:0]. `way_en` is 0 when `req_valid` is 0.
- R3: A way whose enable is 0 never produces a hit, even when the rest of its stored tag would otherwise be compared.
- R4: A request whose full tag (address bits 31:8) equals the stored tag of an enabled way hits. One cycle later it returns `rsp_hit`=1, that way's number on `rsp_way`, and its stored line on `rsp_data`.
- R5: A request with no enabled, fully matching way misses. One cycle later it returns `rsp_hit`=0, `rsp_way`=0 and `rsp_data`=0.
- R6: Several ways may pass the short-tag filter together, but at most one may pass the full compare. The correct way is returned.
- R7: A refill writes the full tag, the short tag, the valid bit and the data of the chosen way on one edge, so a request in any later cycle hits that line.
- R8: A refill into a set with an invalid way fills the lowest-numbered invalid way.
- R9: A refill into a set whose four ways are all valid replaces the way named by that set's own two-bit rotating pointer. The pointer starts at 0 after reset and steps by one (wrapping 3 to 0) on each such replacement. The pointers of other sets are unchanged.
- R10: A cycle with `req_valid`=0 produces `rsp_valid`=0 in the next cycle.
- R11: A request in the same cycle as a refill is looked up against the contents before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address: tag 31:8, set 7:2, byte 1:0 |
| fill_valid | input | 1 | Refill strobe |
| fill_addr | input | 32 | Address of the line being refilled |
| fill_data | input | 32 | Line contents for the refill |
| way_en | output | 4 | Per-way array enable for the current request |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Way that hit, 0 on a miss |
| rsp_data | output | 32 | Line data on a hit, 0 on a miss |

## Verification
The per-way enables are combinational in the request cycle, so the bench checks `way_en` one nanosecond after it drives a request, before the next rising edge. Hit, way and data are registered once and are due at the rising edge that follows the request. The driver queues the expected response when it issues the request. The monitor samples two nanoseconds after each rising edge and takes one entry for every asserted `rsp_valid`. A response without a queued entry, or a queued entry without a response, counts as a failure. Refill effects are checked only through requests in later cycles, apart from the same-cycle case of R11.

// File: rtl/wh_pkg.sv
package wh_pkg;
  localparam int WH_WAYS = 4;
  typedef logic [1:0] way_t;

  // Lowest way whose bit is clear; 0 when none is clear.
  function automatic way_t lowest_clear(input logic [WH_WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = WH_WAYS - 1; i >= 0; i--) begin
      if (!v[i]) r = way_t'(i);
    end
    return r;
  endfunction

  // Encode a one-hot (or empty) vector into a way number.
  function automatic way_t encode_way(input logic [WH_WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = 0; i < WH_WAYS; i++) begin
      if (v[i]) r = way_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/wh_halt_filter.sv
module wh_halt_filter
  import wh_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int HALT_W = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [HALT_W-1:0]    halt_i,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  way_t                 wr_way_i,
  input  logic [HALT_W-1:0]    wr_halt_i,
  output logic [WH_WAYS-1:0]   way_en_o,
  output logic [WH_WAYS-1:0]   wr_row_vld_o
);
  logic [WH_WAYS-1:0][HALT_W-1:0] halt_q [SETS];
  logic [WH_WAYS-1:0]             vld_q  [SETS];
  logic [WH_WAYS-1:0]             pass   [SETS];

  // Every stored short tag is compared at once; the index only selects a row.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WH_WAYS; w++) begin
        pass[s][w] = vld_q[s][w] && (halt_q[s][w] == halt_i);
      end
    end
  end

  assign way_en_o     = req_i ? pass[idx_i] : '0;
  assign wr_row_vld_o = vld_q[wr_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_i) begin
      vld_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_i) halt_q[wr_idx_i][wr_way_i] <= wr_halt_i;
  end

  a_r2_enable_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|way_en_o) |-> req_i);
endmodule

// File: rtl/wh_way_array.sv
module wh_way_array #(
  parameter int SETS   = 64,
  parameter int TAG_W  = 24,
  parameter int LINE_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_data_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] data_mem [SETS];

  // A halted way drives zeros: its arrays are not read.
  assign rd_tag_o  = rd_en_i ? tag_mem[rd_idx_i]  : '0;
  assign rd_data_o = rd_en_i ? data_mem[rd_idx_i] : '0;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/wh_victim_sel.sv
module wh_victim_sel
  import wh_pkg::*;
#(
  parameter int SETS   = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [WH_WAYS-1:0] row_vld_i,
  output way_t               victim_o
);
  way_t rr_q [SETS];
  logic row_full;

  assign row_full = &row_vld_i;
  assign victim_o = row_full ? rr_q[idx_i] : lowest_clear(row_vld_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill_i && row_full) begin
      rr_q[idx_i] <= rr_q[idx_i] + way_t'(1);
    end
  end

  a_r8_fill_takes_empty_way: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !row_full) |-> !row_vld_i[victim_o]);
endmodule

// File: rtl/way_halt_cache.sv
module way_halt_cache
  import wh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int LINE_W = 32,
  parameter int HALT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                fill_valid,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [LINE_W-1:0]   fill_data,
  output logic [WH_WAYS-1:0]  way_en,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [1:0]          rsp_way,
  output logic [LINE_W-1:0]   rsp_data
);
  localparam int OFS_W = $clog2(LINE_W / 8);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [HALT_W-1:0] halt_of(input logic [TAG_W-1:0] t);
    return t[HALT_W-1:0];
  endfunction

  logic [IDX_W-1:0]  req_idx, fill_idx;
  logic [TAG_W-1:0]  req_tag, fill_tag;
  logic [WH_WAYS-1:0] fill_row_vld;
  logic [WH_WAYS-1:0] full_match;
  logic [TAG_W-1:0]  way_tag  [WH_WAYS];
  logic [LINE_W-1:0] way_data [WH_WAYS];
  logic [LINE_W-1:0] hit_data;
  logic [WH_WAYS-1:0] en_q;
  way_t victim;
  logic unused_ofs;

  assign req_idx    = idx_of(req_addr);
  assign req_tag    = tag_of(req_addr);
  assign fill_idx   = idx_of(fill_addr);
  assign fill_tag   = tag_of(fill_addr);
  assign unused_ofs = ^{req_addr[OFS_W-1:0], fill_addr[OFS_W-1:0]};

  wh_halt_filter #(.SETS(SETS), .HALT_W(HALT_W)) u_filter (
    .clk(clk), .rst_n(rst_n),
    .req_i(req_valid), .idx_i(req_idx), .halt_i(halt_of(req_tag)),
    .wr_i(fill_valid), .wr_idx_i(fill_idx), .wr_way_i(victim),
    .wr_halt_i(halt_of(fill_tag)),
    .way_en_o(way_en), .wr_row_vld_o(fill_row_vld)
  );

  wh_victim_sel #(.SETS(SETS)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_i(fill_valid), .idx_i(fill_idx),
    .row_vld_i(fill_row_vld), .victim_o(victim)
  );

  for (genvar w = 0; w < WH_WAYS; w++) begin : g_way
    wh_way_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_arr (
      .clk(clk),
      .rd_en_i(way_en[w]), .rd_idx_i(req_idx),
      .wr_en_i(fill_valid && (victim == way_t'(w))),
      .wr_idx_i(fill_idx), .wr_tag_i(fill_tag), .wr_data_i(fill_data),
      .rd_tag_o(way_tag[w]), .rd_data_o(way_data[w])
    );
    assign full_match[w] = way_en[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WH_WAYS; w++) begin
      if (full_match[w]) hit_data = hit_data | way_data[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_data  <= '0;
      en_q      <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= |full_match;
      rsp_way   <= encode_way(full_match);
      rsp_data  <= hit_data;
      en_q      <= way_en;
    end
  end

  a_r6_single_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(full_match) <= 1);
  a_r3_hit_from_enabled_way: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> en_q[rsp_way]);
  a_r10_idle_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r5_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_way == '0));
endmodule

// File: tb/way_halt_cache_test.sv
`timescale 1ns/1ps
module way_halt_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [31:0] fill_data = '0;
  logic [3:0]  way_en;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_data;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        hit;
    logic [1:0]  way;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model
  logic [23:0] mtag  [64][4];
  logic        mval  [64][4];
  logic [31:0] mdata [64][4];
  logic [1:0]  mrr   [64];

  always #4 clk = ~clk;

  way_halt_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .way_en(way_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_data(rsp_data)
  );

  function automatic logic [31:0] mk(input logic [23:0] t, input int s);
    return {t, 6'(s), 2'b00};
  endfunction
  function automatic logic [31:0] dat(input logic [23:0] t, input int s);
    return {t[15:0], 16'h0} ^ 32'h5A5A_C3C3 ^ 32'(s * 7);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle of stimulus; called at a falling edge, returns at the next one.
  task automatic cyc(input string tag, input bit rv, input logic [31:0] ra,
                     input bit fv, input logic [31:0] fa);
    logic [3:0] e;
    exp_t x;
    int s;
    logic [23:0] t;
    req_valid  = rv;
    req_addr   = ra;
    fill_valid = fv;
    fill_addr  = fa;
    fill_data  = dat(fa[31:8], int'(fa[7:2]));
    #1;
    s = int'(ra[7:2]);
    t = ra[31:8];
    e = '0;
    x.hit = 1'b0; x.way = '0; x.data = '0; x.tag = tag;
    for (int w = 0; w < 4; w++) begin
      if (rv && mval[s][w] && mtag[s][w][3:0] == t[3:0]) begin
        e[w] = 1'b1;
        if (mtag[s][w] == t) begin
          x.hit = 1'b1; x.way = 2'(w); x.data = mdata[s][w];
        end
      end
    end
    check(tag, "way_en", 32'(way_en), 32'(e));
    if (rv) sb.push_back(x);
    if (fv) begin
      int fs, v;
      bit full;
      fs = int'(fa[7:2]);
      full = 1'b1; v = 0;
      for (int w = 3; w >= 0; w--) if (!mval[fs][w]) begin full = 1'b0; v = w; end
      if (full) begin v = int'(mrr[fs]); mrr[fs] = mrr[fs] + 2'd1; end
      mval[fs][v] = 1'b1;
      mtag[fs][v] = fa[31:8];
      mdata[fs][v] = dat(fa[31:8], fs);
    end
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b0;
  endtask

  task automatic req(input string tag, input logic [23:0] t, input int s);
    cyc(tag, 1'b1, mk(t, s), 1'b0, '0);
  endtask
  task automatic fill(input string tag, input logic [23:0] t, input int s);
    cyc(tag, 1'b0, '0, 1'b1, mk(t, s));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (rsp_valid) begin
          if (sb.size() == 0) begin
            checks++; failures++;
            $display("FAIL R10 unexpected response actual=1 expected=0");
          end else begin
            exp_t x;
            x = sb.pop_front();
            check(x.tag, "rsp_hit (R4/R5)", 32'(rsp_hit), 32'(x.hit));
            check(x.tag, "rsp_way", 32'(rsp_way), 32'(x.way));
            check(x.tag, "rsp_data", rsp_data, x.data);
          end
        end else if (sb.size() != 0) begin
          checks++; failures++;
          $display("FAIL R4 missing response actual=0 expected=1");
          void'(sb.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 64; s++) begin
      mrr[s] = '0;
      for (int w = 0; w < 4; w++) begin
        mval[s][w] = 1'b0; mtag[s][w] = '0; mdata[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    check("R1", "way_en in reset", 32'(way_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    req("R1", 24'h000001, 5);
    req("R1", 24'h000000, 0);

    // R8: empty ways filled lowest first; R7: later hits
    fill("R8", 24'h000A01, 5);
    fill("R8", 24'h000A02, 5);
    fill("R8", 24'h000A03, 5);
    fill("R8", 24'h000A04, 5);
    req("R7", 24'h000A01, 5);
    req("R7", 24'h000A02, 5);
    req("R8", 24'h000A03, 5);
    req("R8", 24'h000A04, 5);

    // R2/R5: short tag passes, full tag differs; R3: nothing passes
    req("R2", 24'h000B01, 5);
    req("R5", 24'h123403, 5);
    req("R3", 24'h000A05, 5);

    // R6: two ways share short tag bits
    fill("R6", 24'h000010, 7);
    fill("R6", 24'h000020, 7);
    req("R6", 24'h000020, 7);
    req("R6", 24'h000010, 7);
    req("R6", 24'h000030, 7);

    // R9: rotating replacement, per set
    fill("R9", 24'h000C01, 5);
    fill("R9", 24'h000C02, 5);
    req("R9", 24'h000A01, 5);
    req("R9", 24'h000A02, 5);
    req("R9", 24'h000C01, 5);
    req("R9", 24'h000C02, 5);
    req("R9", 24'h000A03, 5);
    fill("R9", 24'h000030, 7);
    fill("R9", 24'h000040, 7);
    fill("R9", 24'h000050, 7);
    req("R9", 24'h000050, 7);
    req("R9", 24'h000010, 7);
    req("R9", 24'h000040, 7);

    // R11: request and refill in one cycle
    cyc("R11", 1'b1, mk(24'h00ABCD, 9), 1'b1, mk(24'h00ABCD, 9));
    req("R11", 24'h00ABCD, 9);

    // R10: idle cycles
    cyc("R10", 1'b0, mk(24'h00ABCD, 9), 1'b0, '0);
    cyc("R10", 1'b0, '0, 1'b0, '0);
    #3;
    check("R10", "rsp_valid idle", 32'(rsp_valid), 0);

    // mixed traffic: miss then refill
    for (int i = 0; i < 300; i++) begin
      logic [23:0] pool [6];
      int s;
      logic [23:0] t;
      bit present;
      pool[0] = 24'h000010; pool[1] = 24'h000020; pool[2] = 24'h000011;
      pool[3] = 24'hABC010; pool[4] = 24'h000031; pool[5] = 24'h123454;
      s = 20 + ($urandom % 2);
      t = pool[$urandom % 6];
      present = 1'b0;
      for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) present = 1'b1;
      req(present ? "R4" : "R5", t, s);
      if (!present) fill("R7", t, s);
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule